// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer

This block is the control unit of a non-overlapped, multi-cycle 32-bit RISC datapath. It reads the opcode and function fields held in the instruction register and the zero flag of the ALU. From these it drives one set of datapath strobes and selects in each cycle. Every instruction first passes through a common fetch state and a common decode state. The path after decode depends on the instruction class, so an instruction takes three, four or five cycles. The next instruction is fetched only after the last state of the current one.

Five classes are recognised. The register-register class works on operands A and B with the operation named by the function field, then writes the result to rd. The logic-immediate class ORs A with the zero-extended immediate, then writes to rt. Loads add the sign-extended immediate to A to form an address, read data memory, and write the data to rt. Stores form the same address and write B to memory. Branch-if-equal subtracts B from A and loads the PC with the branch target in that same cycle when the ALU reports zero. An opcode that is not recognised, or a register-register function code that is not supported, returns to fetch straight after decode and writes nothing.

Reset is asynchronous and active low. Its release passes through a synchroniser inside the block. While reset is held, or not yet released internally, every strobe is low.

Top module: `mcs_seq_ctrl`

## Requirements
- R1: While `rst_n` is low all outputs are 0. After `rst_n` rises, the outputs stay 0 until the second rising clock edge. From that edge on, the block shows the fetch state. Asserting `rst_n` in the middle of an instruction clears all outputs at once.
- R2: In the fetch state `pc_we`=1 and `ir_we`=1, and all other outputs are 0 (`pc_sel`=0 picks PC+4, `alu_b_sel`=0, `alu_op`=0). `ir_we` is 1 in no other state.
- R3: The cycle after fetch is always decode. In decode `opnd_we`=1 and all other outputs are 0.
- R4: Opcode 0x00 with function 0x20/0x22/0x24/0x25/0x2A is register-register and takes 4 cycles. Execute has `alu_b_sel`=0 (B) and `alu_op` = 0 (add), 1 (sub), 2 (and), 3 (or) or 4 (set-less-than) for those function codes. Write-back has `rf_we`=1, `rf_dst_rd`=1 and `mem_to_reg`=0.
- R5: Opcode 0x0D is logic-immediate and takes 4 cycles. Execute has `alu_b_sel`=2 (zero-extended immediate) and `alu_op`=3. Write-back has `rf_we`=1, `rf_dst_rd`=0 and `mem_to_reg`=0.
- R6: Opcode 0x23 is a load and takes 5 cycles. Execute has `alu_b_sel`=1 (sign-extended immediate) and `alu_op`=0. The memory state has `mem_rd`=1. Write-back has `rf_we`=1, `rf_dst_rd`=0 and `mem_to_reg`=1.
- R7: Opcode 0x2B is a store and takes 4 cycles. Execute is the same as for a load. The memory state has `mem_wr`=1. There is no register write.
- R8: Opcode 0x04 is branch-if-equal and takes 3 cycles. Execute has `alu_b_sel`=0, `alu_op`=1 and `pc_sel`=1, and `pc_we` equals `alu_zero` in that same cycle.
- R9: Any other opcode, or opcode 0x00 with any other function code, goes from decode back to fetch with no write of any kind.
- R10: `mem_rd` and `mem_wr` are never 1 in the same cycle.
- R11: `alu_zero` has no effect on any output outside the branch execute state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| opcode | input | 6 | Opcode field of the instruction register |
| funct | input | 6 | Function field of the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| pc_we | output | 1 | PC load enable |
| pc_sel | output | 1 | Next-PC source: 0 = PC+4, 1 = branch target |
| ir_we | output | 1 | Instruction register load enable |
| opnd_we | output | 1 | Load enable for operand latches A and B |
| rf_we | output | 1 | Register file write enable |
| rf_dst_rd | output | 1 | Destination select: 1 = rd, 0 = rt |
| alu_b_sel | output | 2 | ALU B source: 0 = B, 1 = sign-extended imm, 2 = zero-extended imm |
| alu_op | output | 3 | ALU operation: 0 add, 1 sub, 2 and, 3 or, 4 set-less-than |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| mem_to_reg | output | 1 | Write-back source: 1 = memory data, 0 = ALU result |

## Verification
The assertions check on every cycle the relations that hold between adjacent cycles:
- instruction-register load only in a quiet fetch cycle;
- decode always following fetch;
- exclusive memory strobes;
- a memory read always followed by a memory-sourced register write;
- a store or a register write always followed by a fetch;
- the branch PC load following the zero flag.

Only the bench's scenarios can show the full per-class cycle counts, the selects in each state and the ALU code chosen for every function value. The bench sweeps every opcode and every register-register function code with the zero flag at both values. The same scenarios show that unknown encodings return after decode, and how the outputs behave across a reset taken in mid-instruction.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [3:0] {
    ST_FETCH     = 4'd0,
    ST_DECODE    = 4'd1,
    ST_EX_REG    = 4'd2,
    ST_EX_LOGI   = 4'd3,
    ST_EX_ADDR   = 4'd4,
    ST_EX_BR     = 4'd5,
    ST_MEM_RD    = 4'd6,
    ST_MEM_WR    = 4'd7,
    ST_WB_ALU_RD = 4'd8,
    ST_WB_ALU_RT = 4'd9,
    ST_WB_MEM    = 4'd10
  } mcs_state_e;

  typedef enum logic [2:0] {
    CL_REG    = 3'd0,
    CL_LOGI   = 3'd1,
    CL_LOAD   = 3'd2,
    CL_STORE  = 3'd3,
    CL_BRANCH = 3'd4,
    CL_NONE   = 3'd5
  } mcs_class_e;

  typedef enum logic [2:0] {
    AOP_ADD = 3'd0,
    AOP_SUB = 3'd1,
    AOP_AND = 3'd2,
    AOP_OR  = 3'd3,
    AOP_SLT = 3'd4
  } mcs_aop_e;

  typedef enum logic [1:0] {
    BSRC_REG  = 2'd0,
    BSRC_SEXT = 2'd1,
    BSRC_ZEXT = 2'd2
  } mcs_bsrc_e;

  typedef struct packed {
    logic      pc_we;
    logic      pc_sel;
    logic      ir_we;
    logic      opnd_we;
    logic      rf_we;
    logic      rf_dst_rd;
    mcs_bsrc_e b_src;
    mcs_aop_e  aop;
    logic      mem_rd;
    logic      mem_wr;
    logic      mem_to_reg;
  } mcs_ctl_t;

endpackage

// File: rtl/mcs_rst_sync.sv
module mcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;

  // Assertion is asynchronous; release ripples through STAGES flops (STAGES >= 2).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/mcs_classify.sv
module mcs_classify
  import mcs_pkg::*;
#(
  parameter int              OPC_W     = 6,
  parameter int              FN_W      = 6,
  parameter logic [OPC_W-1:0] OPC_REG   = 6'h00,
  parameter logic [OPC_W-1:0] OPC_LOGI  = 6'h0D,
  parameter logic [OPC_W-1:0] OPC_LOAD  = 6'h23,
  parameter logic [OPC_W-1:0] OPC_STORE = 6'h2B,
  parameter logic [OPC_W-1:0] OPC_BEQ   = 6'h04,
  parameter logic [FN_W-1:0]  FN_ADD    = 6'h20,
  parameter logic [FN_W-1:0]  FN_SUB    = 6'h22,
  parameter logic [FN_W-1:0]  FN_AND    = 6'h24,
  parameter logic [FN_W-1:0]  FN_OR     = 6'h25,
  parameter logic [FN_W-1:0]  FN_SLT    = 6'h2A
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output mcs_class_e       cls,
  output mcs_aop_e         reg_aop
);

  always_comb begin
    cls     = CL_NONE;
    reg_aop = AOP_ADD;
    if (opcode == OPC_REG) begin
      cls = CL_REG;
      if      (funct == FN_ADD) reg_aop = AOP_ADD;
      else if (funct == FN_SUB) reg_aop = AOP_SUB;
      else if (funct == FN_AND) reg_aop = AOP_AND;
      else if (funct == FN_OR)  reg_aop = AOP_OR;
      else if (funct == FN_SLT) reg_aop = AOP_SLT;
      else                      cls     = CL_NONE;
    end else if (opcode == OPC_LOGI) begin
      cls = CL_LOGI;
    end else if (opcode == OPC_LOAD) begin
      cls = CL_LOAD;
    end else if (opcode == OPC_STORE) begin
      cls = CL_STORE;
    end else if (opcode == OPC_BEQ) begin
      cls = CL_BRANCH;
    end
  end

endmodule

// File: rtl/mcs_next_state.sv
module mcs_next_state
  import mcs_pkg::*;
(
  input  mcs_state_e state,
  input  mcs_class_e cls,
  output mcs_state_e nxt
);

  always_comb begin
    nxt = ST_FETCH;
    case (state)
      ST_FETCH: nxt = ST_DECODE;
      ST_DECODE: begin
        case (cls)
          CL_REG:    nxt = ST_EX_REG;
          CL_LOGI:   nxt = ST_EX_LOGI;
          CL_LOAD:   nxt = ST_EX_ADDR;
          CL_STORE:  nxt = ST_EX_ADDR;
          CL_BRANCH: nxt = ST_EX_BR;
          default:   nxt = ST_FETCH;
        endcase
      end
      ST_EX_REG:  nxt = ST_WB_ALU_RD;
      ST_EX_LOGI: nxt = ST_WB_ALU_RT;
      ST_EX_ADDR: nxt = (cls == CL_LOAD) ? ST_MEM_RD : ST_MEM_WR;
      ST_MEM_RD:  nxt = ST_WB_MEM;
      default:    nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mcs_out_decode.sv
module mcs_out_decode
  import mcs_pkg::*;
(
  input  mcs_state_e state,
  input  mcs_aop_e   reg_aop,
  input  logic       alu_zero,
  output mcs_ctl_t   ctl
);

  always_comb begin
    ctl = '0;
    case (state)
      ST_FETCH: begin
        ctl.ir_we = 1'b1;
        ctl.pc_we = 1'b1;
      end
      ST_DECODE:  ctl.opnd_we = 1'b1;
      ST_EX_REG: begin
        ctl.b_src = BSRC_REG;
        ctl.aop   = reg_aop;
      end
      ST_EX_LOGI: begin
        ctl.b_src = BSRC_ZEXT;
        ctl.aop   = AOP_OR;
      end
      ST_EX_ADDR: begin
        ctl.b_src = BSRC_SEXT;
        ctl.aop   = AOP_ADD;
      end
      ST_EX_BR: begin
        ctl.b_src  = BSRC_REG;
        ctl.aop    = AOP_SUB;
        ctl.pc_sel = 1'b1;
        ctl.pc_we  = alu_zero;
      end
      ST_MEM_RD: ctl.mem_rd = 1'b1;
      ST_MEM_WR: ctl.mem_wr = 1'b1;
      ST_WB_ALU_RD: begin
        ctl.rf_we     = 1'b1;
        ctl.rf_dst_rd = 1'b1;
      end
      ST_WB_ALU_RT: ctl.rf_we = 1'b1;
      ST_WB_MEM: begin
        ctl.rf_we      = 1'b1;
        ctl.mem_to_reg = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/mcs_seq_ctrl.sv
module mcs_seq_ctrl
  import mcs_pkg::*;
#(
  parameter int OPC_W       = 6,
  parameter int FN_W        = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  input  logic             alu_zero,
  output logic             pc_we,
  output logic             pc_sel,
  output logic             ir_we,
  output logic             opnd_we,
  output logic             rf_we,
  output logic             rf_dst_rd,
  output logic [1:0]       alu_b_sel,
  output logic [2:0]       alu_op,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             mem_to_reg
);

  logic       rst_sync_n;
  mcs_state_e state_q;
  mcs_state_e state_d;
  mcs_class_e cls;
  mcs_aop_e   reg_aop;
  mcs_ctl_t   ctl_raw;
  mcs_ctl_t   ctl_out;
  logic       state_en;

  mcs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mcs_classify #(.OPC_W(OPC_W), .FN_W(FN_W)) u_classify (
    .opcode  (opcode),
    .funct   (funct),
    .cls     (cls),
    .reg_aop (reg_aop)
  );

  mcs_next_state u_next (
    .state (state_q),
    .cls   (cls),
    .nxt   (state_d)
  );

  // The sequencer advances every cycle once out of reset.
  assign state_en = 1'b1;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   state_q <= ST_FETCH;
    else if (state_en) state_q <= state_d;
  end

  mcs_out_decode u_out (
    .state    (state_q),
    .reg_aop  (reg_aop),
    .alu_zero (alu_zero),
    .ctl      (ctl_raw)
  );

  assign ctl_out    = rst_sync_n ? ctl_raw : '0;

  assign pc_we      = ctl_out.pc_we;
  assign pc_sel     = ctl_out.pc_sel;
  assign ir_we      = ctl_out.ir_we;
  assign opnd_we    = ctl_out.opnd_we;
  assign rf_we      = ctl_out.rf_we;
  assign rf_dst_rd  = ctl_out.rf_dst_rd;
  assign alu_b_sel  = ctl_out.b_src;
  assign alu_op     = ctl_out.aop;
  assign mem_rd     = ctl_out.mem_rd;
  assign mem_wr     = ctl_out.mem_wr;
  assign mem_to_reg = ctl_out.mem_to_reg;

endmodule

// File: rtl/mcs_seq_ctrl_chk.sv
module mcs_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       alu_zero,
  input logic       pc_we,
  input logic       pc_sel,
  input logic       ir_we,
  input logic       opnd_we,
  input logic       rf_we,
  input logic       rf_dst_rd,
  input logic [1:0] alu_b_sel,
  input logic [2:0] alu_op,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       mem_to_reg
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !(pc_we || pc_sel || ir_we || opnd_we || rf_we || mem_rd || mem_wr)); // R1

  AST_FETCH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    ir_we |-> (pc_we && !pc_sel && !opnd_we && !rf_we && !mem_rd && !mem_wr)); // R2

  AST_DECODE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ir_we |=> (opnd_we && !ir_we)); // R3

  AST_RFWE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && !mem_to_reg) |=> ir_we); // R4

  AST_LOAD_WB: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (rf_we && mem_to_reg && !rf_dst_rd)); // R6

  AST_STORE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> ir_we); // R7

  AST_BRANCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel |-> (pc_we == alu_zero && alu_op == 3'd1 && alu_b_sel == 2'd0)); // R8

  AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R10

endmodule

bind mcs_seq_ctrl mcs_seq_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .alu_zero   (alu_zero),
  .pc_we      (pc_we),
  .pc_sel     (pc_sel),
  .ir_we      (ir_we),
  .opnd_we    (opnd_we),
  .rf_we      (rf_we),
  .rf_dst_rd  (rf_dst_rd),
  .alu_b_sel  (alu_b_sel),
  .alu_op     (alu_op),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .mem_to_reg (mem_to_reg)
);

// File: tb/mcs_seq_ctrl_tb.sv
module mcs_seq_ctrl_tb;

  logic       clk;
  logic       rst_n;
  logic [5:0] opcode;
  logic [5:0] funct;
  logic       alu_zero;
  logic       pc_we, pc_sel, ir_we, opnd_we, rf_we, rf_dst_rd;
  logic [1:0] alu_b_sel;
  logic [2:0] alu_op;
  logic       mem_rd, mem_wr, mem_to_reg;

  int checks;
  int errors;
  bit done;

  mcs_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct), .alu_zero(alu_zero),
    .pc_we(pc_we), .pc_sel(pc_sel), .ir_we(ir_we), .opnd_we(opnd_we), .rf_we(rf_we),
    .rf_dst_rd(rf_dst_rd), .alu_b_sel(alu_b_sel), .alu_op(alu_op), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_to_reg(mem_to_reg)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [13:0] obs();
    return {pc_we, pc_sel, ir_we, opnd_we, rf_we, rf_dst_rd, alu_b_sel, alu_op,
            mem_rd, mem_wr, mem_to_reg};
  endfunction

  function automatic logic [13:0] mk(logic pw, logic ps, logic iw, logic ow, logic rw,
                                     logic rd, logic [1:0] bs, logic [2:0] ao,
                                     logic mr, logic mw, logic m2r);
    return {pw, ps, iw, ow, rw, rd, bs, ao, mr, mw, m2r};
  endfunction

  // classes: 0 reg, 1 logic-imm, 2 load, 3 store, 4 branch, 5 none
  function automatic int class_of(logic [5:0] op, logic [5:0] fn);
    if (op == 6'h00) begin
      if (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25 || fn == 6'h2A) return 0;
      return 5;
    end
    if (op == 6'h0D) return 1;
    if (op == 6'h23) return 2;
    if (op == 6'h2B) return 3;
    if (op == 6'h04) return 4;
    return 5;
  endfunction

  function automatic logic [2:0] aop_of(logic [5:0] fn);
    case (fn)
      6'h22:   return 3'd1;
      6'h24:   return 3'd2;
      6'h25:   return 3'd3;
      6'h2A:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic int len_of(int c);
    case (c)
      0, 1, 3: return 4;
      2:       return 5;
      4:       return 3;
      default: return 2;
    endcase
  endfunction

  function automatic logic [13:0] expect_of(int c, int step, logic z, logic [5:0] fn);
    if (step == 0) return mk(1,0,1,0,0,0,2'd0,3'd0,0,0,0);
    if (step == 1) return mk(0,0,0,1,0,0,2'd0,3'd0,0,0,0);
    case (c)
      0: return (step == 2) ? mk(0,0,0,0,0,0,2'd0,aop_of(fn),0,0,0)
                            : mk(0,0,0,0,1,1,2'd0,3'd0,0,0,0);
      1: return (step == 2) ? mk(0,0,0,0,0,0,2'd2,3'd3,0,0,0)
                            : mk(0,0,0,0,1,0,2'd0,3'd0,0,0,0);
      2: return (step == 2) ? mk(0,0,0,0,0,0,2'd1,3'd0,0,0,0)
              : (step == 3) ? mk(0,0,0,0,0,0,2'd0,3'd0,1,0,0)
                            : mk(0,0,0,0,1,0,2'd0,3'd0,0,0,1);
      3: return (step == 2) ? mk(0,0,0,0,0,0,2'd1,3'd0,0,0,0)
                            : mk(0,0,0,0,0,0,2'd0,3'd0,0,1,0);
      4: return mk(z,1,0,0,0,0,2'd0,3'd1,0,0,0);
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(int c, int step, logic z);
    if (step == 0) return "R2";
    if (step == 1) return "R3";
    if (z && c != 4) return "R11";
    case (c)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [13:0] act, logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Entered at a negedge inside a fetch cycle; leaves at the negedge of the next fetch cycle.
  task automatic run_instr(logic [5:0] op, logic [5:0] fn, logic z);
    int c;
    c = class_of(op, fn);
    opcode = op;
    funct = fn;
    alu_zero = z;
    for (int step = 0; step < len_of(c); step++) begin
      if (step > 0) @(negedge clk);
      #1;
      check(tag_of(c, step, z), obs(), expect_of(c, step, z, fn));
      checks++;
      if (mem_rd && mem_wr) begin
        errors++;
        $display("FAIL R10 actual=%b%b expected=not both", mem_rd, mem_wr);
      end
    end
    @(negedge clk);
    if (c == 5) begin
      #1;
      check("R9", obs(), expect_of(0, 0, 1'b0, 6'h0));
    end
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check("R1", obs(), '0);
    @(negedge clk);
    #1 check("R1", obs(), expect_of(0, 0, 1'b0, 6'h0));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done = 1'b0;
    rst_n = 1'b0;
    opcode = 6'h0;
    funct = 6'h0;
    alu_zero = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 check("R1", obs(), '0);
    release_reset();

    for (int op = 0; op < 64; op++) begin
      for (int z = 0; z < 2; z++) run_instr(6'(op), 6'h20, 1'(z));
    end
    for (int fn = 0; fn < 64; fn++) begin
      for (int z = 0; z < 2; z++) run_instr(6'h00, 6'(fn), 1'(z));
    end

    // reset taken in the memory-read state of a load
    opcode = 6'h23;
    funct = 6'h00;
    alu_zero = 1'b0;
    repeat (3) @(negedge clk);
    #1 check("R6", obs(), expect_of(2, 3, 1'b0, 6'h0));
    rst_n = 1'b0;
    #1 check("R1", obs(), '0);
    @(negedge clk);
    #1 check("R1", obs(), '0);
    release_reset();
    run_instr(6'h2B, 6'h00, 1'b1);
    run_instr(6'h04, 6'h00, 1'b1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule